// File: doc/BRIEF.md
# Event Counter Monitor with Overflow Sampling

This block counts hardware events for profiling. It has up to six 32-bit counters that count upward. Each counter has an event selector that chooses between no event, every clock cycle, or one line of an event input vector. Counting is allowed only when every freeze condition is clear. The freeze conditions are a global freeze, a freeze for each privilege mode, a freeze for each level of a process mark, and an external hold input.

Software uses a simple word-indexed register bus. Through it, software loads each counter with `0x80000000 - N` and enables the overflow interrupt. When a counter's bit 31 becomes set, the block raises a level interrupt. One cycle later it records the current instruction address. If the freeze-on-overflow option is set, it also sets the global freeze bit, so the counter values stay in place for the handler.

Top module: `pmu_unit`

## Requirements
- R1: After a synchronous active-low reset, the registers hold these values: control word 0 = 0x80000000 (only the global freeze bit set), control word 1 = 0, control word 2 = 0, sampled address = 0, every counter = 0. `irq_o` is 0.
- R2: The bus word index is decoded as 0 = control 0, 1 = control 1, 2 = control 2, 3 = sampled address (read-only), and 4+i = counter i. A write takes effect at the next clock edge and reads back from then on. A counter write wins over an increment in the same cycle.
- R3: Event codes work as follows: code 0 counts nothing, code 1 counts every cycle, and code k≥2 counts each cycle in which `evt_i[k-2]` is high. Counter 0 takes its 6-bit code from control 0 bits [11:6], and counter 1 from control 0 bits [5:0]. Counters 2, 3, 4 and 5 take their 5-bit codes from control 1 bits [31:27], [26:22], [21:17] and [15:11].
- R4: While control 0 bit 31 (global freeze) is 1, no counter changes except through a bus write.
- R5: Control 0 bit 30 freezes counting while `sup_mode_i` is 1. Control 0 bit 29 freezes counting while `sup_mode_i` is 0.
- R6: Control 0 bit 28 freezes counting while `mark_i` is 1. Control 0 bit 27 freezes counting while `mark_i` is 0.
- R7: While `pmm_i` is 1, no counter counts, even when every freeze bit is clear. Counting resumes once `pmm_i` is 0.
- R8: `irq_o` is 1 exactly when control 0 bit 26 (interrupt enable) is 1 and some counter with its overflow enable set has bit 31 equal to 1. Rewriting that counter or clearing bit 26 drops `irq_o` at the next edge.
- R9: At the first edge after the interrupt condition rises, the sampled address register loads `pc_i`. At all other times it keeps its value.
- R10: At that same edge, if control 0 bit 25 (freeze on overflow) is 1, the global freeze bit (control 0 bit 31) becomes 1.
- R11: Control word 2 exists only when NUM_CNT > 4. Otherwise it reads as 0, as do the word indexes of unimplemented counters.
- R12: Control 0 bit 15 is the overflow enable for counter 0. Control 0 bit 14 is a single enable shared by counters 1 and up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 4 | Register word index |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational from index) |
| evt_i | input | NUM_EVT | Event input lines |
| sup_mode_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| mark_i | input | 1 | Process mark level |
| pmm_i | input | 1 | External counting hold |
| pc_i | input | 32 | Current instruction address |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds two copies of the block. The first uses the default of six counters and 24 event lines. It exercises every event selector field, control word 2, and the shared overflow enable on counters 1 and up. The second copy uses four counters. Writes to control word 2 and to the fifth counter's index must read back as zero there, which shows the size-dependent decode. Both copies share one bus, so the same stimulus tests the presence and absence of the optional register.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
// pmu_pkg: shared constants for the event counter monitor.
// Assumes at most six counters; field positions follow the selector layout.
package pmu_pkg;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = 4;
    localparam int WIDE_SEL  = 6;
    localparam int NARROW_SEL = 5;

    // control word 0 bit positions
    localparam int B_FRZ_ALL  = 31;
    localparam int B_FRZ_SUP  = 30;
    localparam int B_FRZ_USR  = 29;
    localparam int B_FRZ_MK1  = 28;
    localparam int B_FRZ_MK0  = 27;
    localparam int B_IRQ_EN   = 26;
    localparam int B_FRZ_HIT  = 25;
    localparam int B_HIT_EN0  = 15;
    localparam int B_HIT_ENN  = 14;
    localparam int SEL0_LSB   = 6;
    localparam int SEL1_LSB   = 0;

    // register word indexes
    localparam int A_CTL0   = 0;
    localparam int A_CTL1   = 1;
    localparam int A_CTL2   = 2;
    localparam int A_SAMPLE = 3;
    localparam int A_CNT0   = 4;

    // lsb of the narrow selector for counter idx (2..5) in control word 1
    function automatic int narrow_lsb(input int idx);
        case (idx)
            2: narrow_lsb = 27;
            3: narrow_lsb = 22;
            4: narrow_lsb = 17;
            default: narrow_lsb = 11;
        endcase
    endfunction
endpackage

// File: rtl/pmu_evt_sel.sv
`timescale 1ns/1ps
// pmu_evt_sel: decodes an event code into a one-cycle count request.
// Code 0 = none, 1 = every cycle, k>=2 = evt_i[k-2]; codes past the
// vector count nothing.
module pmu_evt_sel #(
    parameter int SEL_W   = 6,
    parameter int NUM_EVT = 24
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               hit_o
);
    // pick the selected event line
    always_comb begin
        hit_o = 1'b0;
        if (sel_i == SEL_W'(1)) hit_o = 1'b1;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (int'(sel_i) == k + 2) hit_o = evt_i[k];
        end
    end
endmodule

// File: rtl/pmu_counter.sv
`timescale 1ns/1ps
// pmu_counter: one up-counter; a bus write takes priority over increment.
// Assumes inc_i already folds in every freeze condition.
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // load on write, else count when allowed
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_i)   cnt_q <= wdata_i;
        else if (inc_i)  cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o = cnt_q;

    // R2
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> cnt_q == $past(wdata_i));
    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !inc_i) |=> $stable(cnt_q));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && inc_i) |=> cnt_q == $past(cnt_q) + W'(1));
endmodule

// File: rtl/pmu_unit.sv
`timescale 1ns/1ps
// pmu_unit: event counter monitor top. Holds control words, sampled
// address and NUM_CNT counters; raises a level interrupt on an enabled
// bit-31 condition and samples pc_i one cycle after it rises.
// Assumes 1 <= NUM_CNT <= 6.
module pmu_unit #(
    parameter int NUM_CNT = 6,
    parameter int NUM_EVT = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [pmu_pkg::IDX_W-1:0]  bus_addr_i,
    input  logic                       bus_wr_i,
    input  logic [pmu_pkg::DATA_W-1:0] bus_wdata_i,
    output logic [pmu_pkg::DATA_W-1:0] bus_rdata_o,
    input  logic [NUM_EVT-1:0]         evt_i,
    input  logic                       sup_mode_i,
    input  logic                       mark_i,
    input  logic                       pmm_i,
    input  logic [pmu_pkg::DATA_W-1:0] pc_i,
    output logic                       irq_o
);
    import pmu_pkg::*;

    localparam bit HAS_CTL2 = (NUM_CNT > 4);
    localparam logic [DATA_W-1:0] CTL0_RST = DATA_W'(1) << B_FRZ_ALL;

    logic [DATA_W-1:0] ctl0_q, ctl1_q, ctl2_q, sample_q;
    logic [DATA_W-1:0] cnt_w [NUM_CNT];
    logic [NUM_CNT-1:0] msb_w;
    logic count_ok, trig, trig_q, onset;

    // all freeze conditions folded into one enable
    always_comb begin
        count_ok = !ctl0_q[B_FRZ_ALL] && !pmm_i;
        if (ctl0_q[B_FRZ_SUP] &&  sup_mode_i) count_ok = 1'b0;
        if (ctl0_q[B_FRZ_USR] && !sup_mode_i) count_ok = 1'b0;
        if (ctl0_q[B_FRZ_MK1] &&  mark_i)     count_ok = 1'b0;
        if (ctl0_q[B_FRZ_MK0] && !mark_i)     count_ok = 1'b0;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
            logic [WIDE_SEL-1:0] sel;
            logic                hit;
            logic                wr;
            if (gi == 0) begin : g_s0
                assign sel = ctl0_q[SEL0_LSB +: WIDE_SEL];
            end else if (gi == 1) begin : g_s1
                assign sel = ctl0_q[SEL1_LSB +: WIDE_SEL];
            end else begin : g_sn
                localparam int LSB = narrow_lsb(gi);
                assign sel = {1'b0, ctl1_q[LSB +: NARROW_SEL]};
            end
            pmu_evt_sel #(.SEL_W(WIDE_SEL), .NUM_EVT(NUM_EVT)) u_sel (
                .sel_i(sel), .evt_i(evt_i), .hit_o(hit));
            assign wr = bus_wr_i && (bus_addr_i == IDX_W'(A_CNT0 + gi));
            pmu_counter #(.W(DATA_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .wr_i(wr), .wdata_i(bus_wdata_i),
                .inc_i(hit && count_ok), .cnt_o(cnt_w[gi]));
            assign msb_w[gi] = cnt_w[gi][DATA_W-1];
        end
    endgenerate

    // enabled overflow condition: counter 0 own enable, rest shared
    always_comb begin
        logic rest;
        rest = 1'b0;
        for (int k = 1; k < NUM_CNT; k++) rest = rest | msb_w[k];
        trig = ctl0_q[B_IRQ_EN] &&
               ((ctl0_q[B_HIT_EN0] && msb_w[0]) || (ctl0_q[B_HIT_ENN] && rest));
    end

    assign onset = trig && !trig_q;
    assign irq_o = trig;

    // condition history, control words and sampled address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q   <= 1'b0;
            ctl0_q   <= CTL0_RST;
            ctl1_q   <= '0;
            sample_q <= '0;
        end else begin
            trig_q <= trig;
            if (bus_wr_i && bus_addr_i == IDX_W'(A_CTL0)) ctl0_q <= bus_wdata_i;
            if (onset && ctl0_q[B_FRZ_HIT]) ctl0_q[B_FRZ_ALL] <= 1'b1;
            if (bus_wr_i && bus_addr_i == IDX_W'(A_CTL1)) ctl1_q <= bus_wdata_i;
            if (onset) sample_q <= pc_i;
        end
    end

    generate
        if (HAS_CTL2) begin : g_ctl2
            // optional control word 2, storage only
            always_ff @(posedge clk) begin
                if (!rst_n) ctl2_q <= '0;
                else if (bus_wr_i && bus_addr_i == IDX_W'(A_CTL2)) ctl2_q <= bus_wdata_i;
            end
        end else begin : g_no_ctl2
            assign ctl2_q = '0;
        end
    endgenerate

    // read mux by word index
    always_comb begin
        bus_rdata_o = '0;
        case (int'(bus_addr_i))
            A_CTL0:   bus_rdata_o = ctl0_q;
            A_CTL1:   bus_rdata_o = ctl1_q;
            A_CTL2:   bus_rdata_o = ctl2_q;
            A_SAMPLE: bus_rdata_o = sample_q;
            default:  bus_rdata_o = '0;
        endcase
        for (int k = 0; k < NUM_CNT; k++)
            if (bus_addr_i == IDX_W'(A_CNT0 + k)) bus_rdata_o = cnt_w[k];
    end

    // R9
    sample_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        onset |=> sample_q == $past(pc_i));
    // R9
    sample_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !onset |=> $stable(sample_q));
    // R10
    freeze_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (onset && ctl0_q[B_FRZ_HIT]) |=> ctl0_q[B_FRZ_ALL]);
    // R7
    pmm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmm_i && !bus_wr_i) |=> $stable(cnt_w[0]));
    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl0_q[B_IRQ_EN] |-> !irq_o);
endmodule

// File: tb/tb_pmu_unit.sv
`timescale 1ns/1ps
// tb_pmu_unit: directed scenarios, one task each, self-checking.
module tb_pmu_unit;
    localparam int NE = 24;
    localparam logic [31:0] FC   = 32'h8000_0000;
    localparam logic [31:0] FSUP = 32'h4000_0000;
    localparam logic [31:0] FUSR = 32'h2000_0000;
    localparam logic [31:0] FMK1 = 32'h1000_0000;
    localparam logic [31:0] FMK0 = 32'h0800_0000;
    localparam logic [31:0] IEN  = 32'h0400_0000;
    localparam logic [31:0] FHIT = 32'h0200_0000;
    localparam logic [31:0] EN0  = 32'h0000_8000;
    localparam logic [31:0] ENN  = 32'h0000_4000;
    localparam logic [31:0] SEL0_EV0 = 32'd2 << 6;   // counter 0 counts evt[0]

    logic clk = 0, rst_n = 0;
    logic [3:0] addr = 0;
    logic wr = 0;
    logic [31:0] wdata = 0, rdata, rdata_s, pc = 0;
    logic [NE-1:0] evt = '0;
    logic sup = 0, mark = 0, pmm = 0;
    logic irq, irq_s;
    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    pmu_unit #(.NUM_CNT(6), .NUM_EVT(NE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
        .sup_mode_i(sup), .mark_i(mark), .pmm_i(pmm), .pc_i(pc), .irq_o(irq));

    pmu_unit #(.NUM_CNT(4), .NUM_EVT(NE)) dut_small (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata_s), .evt_i(evt),
        .sup_mode_i(sup), .mark_i(mark), .pmm_i(pmm), .pc_i(pc), .irq_o(irq_s));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input int a, input logic [31:0] d);
        addr = 4'(a); wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic br(input int a, output logic [31:0] v);
        addr = 4'(a); #1; v = rdata;
    endtask

    task automatic pulse(input int idx, input int n);
        evt[idx] = 1;
        repeat (n) @(negedge clk);
        evt[idx] = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        br(0, v); chk("R1 ctl0", v, FC);
        br(1, v); chk("R1 ctl1", v, 0);
        br(2, v); chk("R1 ctl2", v, 0);
        br(3, v); chk("R1 sample", v, 0);
        for (int i = 0; i < 6; i++) begin br(4 + i, v); chk("R1 counter", v, 0); end
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_events;
        logic [31:0] v;
        bw(0, FC);
        bw(1, 32'd3 << 27);                // counter 2 counts evt[1]
        for (int i = 0; i < 6; i++) bw(4 + i, 0);
        bw(0, SEL0_EV0);
        br(1, v); chk("R2 ctl1 readback", v, 32'd3 << 27);
        pulse(0, 5); pulse(1, 3);
        br(4, v); chk("R3 counter0 evt0", v, 5);
        br(5, v); chk("R3 counter1 code0", v, 0);
        br(6, v); chk("R3 counter2 evt1", v, 3);
        // every-cycle code on counter 3
        bw(0, FC | SEL0_EV0);
        bw(1, 32'd1 << 22);
        bw(7, 0);
        bw(0, SEL0_EV0);
        repeat (6) @(negedge clk);
        bw(0, FC | SEL0_EV0);
        br(7, v); chk("R3 every cycle", v, 7);
    endtask

    task automatic t_write_wins;
        logic [31:0] v;
        bw(0, SEL0_EV0);
        bw(7, 100);
        br(7, v); chk("R2 write over increment", v, 100);
        @(negedge clk);
        br(7, v); chk("R2 counts after write", v, 101);
        bw(0, FC | SEL0_EV0);
        br(7, v); chk("R4 freeze edge", v, 102);
        repeat (3) @(negedge clk);
        br(7, v); chk("R4 frozen every cycle", v, 102);
        bw(1, 0);
    endtask

    task automatic t_global_freeze;
        logic [31:0] v;
        bw(4, 9);
        pulse(0, 4);
        br(4, v); chk("R4 global freeze", v, 9);
    endtask

    task automatic t_privilege;
        logic [31:0] v;
        bw(0, FSUP | SEL0_EV0); bw(4, 0);
        sup = 1; pulse(0, 4);
        br(4, v); chk("R5 supervisor frozen", v, 0);
        sup = 0; pulse(0, 3);
        br(4, v); chk("R5 user counts", v, 3);
        bw(0, FUSR | SEL0_EV0);
        pulse(0, 4);
        br(4, v); chk("R5 user frozen", v, 3);
        sup = 1; pulse(0, 2);
        br(4, v); chk("R5 supervisor counts", v, 5);
        sup = 0;
    endtask

    task automatic t_mark;
        logic [31:0] v;
        bw(0, FMK1 | SEL0_EV0); bw(4, 0);
        mark = 1; pulse(0, 4);
        br(4, v); chk("R6 mark1 frozen", v, 0);
        mark = 0; pulse(0, 2);
        br(4, v); chk("R6 mark0 counts", v, 2);
        bw(0, FMK0 | SEL0_EV0);
        pulse(0, 3);
        br(4, v); chk("R6 mark0 frozen", v, 2);
        mark = 1; pulse(0, 1);
        br(4, v); chk("R6 mark1 counts", v, 3);
        mark = 0;
    endtask

    task automatic t_pmm;
        logic [31:0] v;
        bw(0, SEL0_EV0); bw(4, 0);
        pmm = 1; pulse(0, 3);
        br(4, v); chk("R7 held by pmm", v, 0);
        pmm = 0; pulse(0, 2);
        br(4, v); chk("R7 resumes", v, 2);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        bw(0, FC | SEL0_EV0);
        bw(4, 32'h7FFF_FFFE);
        pc = 32'h1234_5678;
        bw(0, IEN | FHIT | EN0 | SEL0_EV0);
        chk("R8 no irq below msb", {31'b0, irq}, 0);
        pulse(0, 2);
        chk("R8 irq at msb", {31'b0, irq}, 1);
        br(4, v); chk("R3 reached msb", v, 32'h8000_0000);
        @(negedge clk);
        pc = 32'hDEAD_BEEF;
        br(3, v); chk("R9 sampled address", v, 32'h1234_5678);
        br(0, v); chk("R10 freeze set", v & FC, FC);
        @(negedge clk);
        br(3, v); chk("R9 sample held", v, 32'h1234_5678);
        chk("R8 irq stays", {31'b0, irq}, 1);
        bw(4, 0);
        chk("R8 irq cleared by rewrite", {31'b0, irq}, 0);
    endtask

    task automatic t_shared_enable;
        logic [31:0] v;
        bw(0, IEN | ENN);
        bw(4, 32'h8000_0000);
        chk("R12 counter0 not enabled by shared", {31'b0, irq}, 0);
        bw(6, 32'h8000_0000);
        chk("R12 counter2 shared enable", {31'b0, irq}, 1);
        bw(0, ENN);
        chk("R8 irq off with enable clear", {31'b0, irq}, 0);
        br(0, v); chk("R10 no freeze without option", v & FC, 0);
        bw(6, 0); bw(4, 0); bw(0, FC);
    endtask

    task automatic t_sizes;
        logic [31:0] v;
        bw(2, 32'hA5A5_0F0F);
        br(2, v); chk("R11 ctl2 present", v, 32'hA5A5_0F0F);
        chk("R11 ctl2 absent reads 0", rdata_s, 0);
        bw(8, 55);
        br(8, v); chk("R11 counter4 present", v, 55);
        chk("R11 counter4 absent reads 0", rdata_s, 0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_events;
        t_write_wins;
        t_global_freeze;
        t_privilege;
        t_mark;
        t_pmm;
        t_overflow;
        t_shared_enable;
        t_sizes;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule